// File: doc/BRIEF.md
# Interrupt Pending and Masking Unit

This block keeps the interrupt-pending state for a small RISC core, one bit per level. A command port sets one level, clears one level, or wipes the whole vector. A level number outside the legal range is rejected and flagged. A count/compare timer is folded into the same vector. When the 32-bit count input equals the compare input and the count is not zero, the level chosen by a 3-bit select field becomes pending. A strobe marks a write of a new compare value, and that strobe drops the selected timer level.

The block gates the pending vector with an 8-bit mask, a global enable and two blocking status bits (exception level and error level). From this it produces a registered interrupt request. A separate flag reports any pending level without regard to masking. The free-running counter, the bus decode and the vector dispatch all live outside this block.

Top module: `irq_pend_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the vector `pend_out`, `irq`, `cmd_err` and `any_pend` are all 0 after that edge.
- R2: With `cmd_valid`=1, `cmd_op`=2'b01 (post) and `cmd_level`=n, where n is in 0..7, bit n of `pend_out` is set after the edge. Bit 0 is the LSB. No other bit changes because of the command.
- R3: With `cmd_op`=2'b10 (clear) and a legal level n, only bit n of `pend_out` is cleared after the edge.
- R4: With `cmd_op`=2'b11 (clear-all), every pending bit goes to 0 after the edge. The only exception is a bit set in the same cycle (see R9). `cmd_op`=2'b00 is idle.
- R5: A post or clear whose `cmd_level` is in 8..15 leaves the vector untouched by the command. `cmd_err` is 1 for the cycle after that edge and 0 otherwise.
- R6: When `count_in` == `compare_in` and `count_in` != 0, bit `tsel` of `pend_out` is set after the edge.
- R7: When `count_in` is 0, equality with `compare_in` sets no bit.
- R8: `compare_wr`=1 clears bit `tsel` after the edge. The bit stays clear until a later timer match or post.
- R9: Within one edge, clear-all acts first, then single-bit clears (command and compare write), then sets (post and timer match). A set and a clear of the same bit leave it set.
- R10: `irq` is registered. After each edge it equals `gie` & !`exl` & !`erl` & |(`mask` & `pend_out`), evaluated on the values present before that edge.
- R11: `any_pend` is 1 exactly when `pend_out` is nonzero, whatever the state of `mask`, `gie`, `exl` and `erl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 post, 10 clear, 11 clear-all, 00 idle |
| cmd_level | input | 4 | Target level for post/clear |
| count_in | input | 32 | Free-running counter value |
| compare_in | input | 32 | Timer compare value |
| compare_wr | input | 1 | Compare register written this cycle |
| tsel | input | 3 | Level used by the timer |
| gie | input | 1 | Global interrupt enable |
| exl | input | 1 | Exception level, blocks requests |
| erl | input | 1 | Error level, blocks requests |
| mask | input | 8 | Per-level enable mask |
| pend_out | output | 8 | Pending vector |
| any_pend | output | 1 | Vector nonzero |
| irq | output | 1 | Registered interrupt request |
| cmd_err | output | 1 | Illegal level seen last cycle |

## Verification
The bench targets these corner cases:
- Out-of-range levels 8 to 15. A design that decodes only the low three bits would alias such a level onto a legal bit, or would leave `cmd_err` quiet.
- A zero count that equals compare. Missing the zero check raises a spurious timer level.
- A compare write in the same cycle as a timer match or a post to that bit. Wrong clear/set ordering would drop the bit.
- A timer match during clear-all. Getting this wrong wipes the new set.
- `irq` under each blocking bit and under a mask that excludes every pending bit. An unregistered or ungated request shows up one cycle early or while blocked.

A random mix then compares every output against the reference on every cycle.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'b00,
    OP_POST   = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_CLRALL = 2'b11
  } pend_op_e;
endpackage

// File: rtl/ipm_timer_match.sv
module ipm_timer_match #(
  parameter int CNTW = 32
) (
  input  logic [CNTW-1:0] count_in,
  input  logic [CNTW-1:0] compare_in,
  output logic            hit
);
  always_comb begin
    hit = (count_in == compare_in) && (count_in != '0);
  end
endmodule

// File: rtl/ipm_pend_reg.sv
module ipm_pend_reg
  import irq_pend_pkg::*;
#(
  parameter int NLVL = 8,
  parameter int LVLW = 4,
  parameter int SELW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [LVLW-1:0] cmd_level,
  input  logic            timer_hit,
  input  logic            compare_wr,
  input  logic [SELW-1:0] tsel,
  output logic [NLVL-1:0] pend_q,
  output logic            err_q
);
  pend_op_e         op;
  logic             level_ok;
  logic             do_post;
  logic             do_clear;
  logic             do_wipe;
  logic             bad_cmd;
  logic [NLVL-1:0]  set_v;
  logic [NLVL-1:0]  clr_v;
  logic [NLVL-1:0]  base_v;

  always_comb begin
    op       = pend_op_e'(cmd_op);
    level_ok = int'(cmd_level) < NLVL;
    do_post  = cmd_valid && (op == OP_POST) && level_ok;
    do_clear = cmd_valid && (op == OP_CLEAR) && level_ok;
    do_wipe  = cmd_valid && (op == OP_CLRALL);
    bad_cmd  = cmd_valid && ((op == OP_POST) || (op == OP_CLEAR)) && !level_ok;
    base_v   = do_wipe ? '0 : pend_q;
  end

  for (genvar i = 0; i < NLVL; i++) begin : g_bit
    assign set_v[i] = (do_post && (cmd_level == LVLW'(i))) ||
                      (timer_hit && (tsel == SELW'(i)));
    assign clr_v[i] = (do_clear && (cmd_level == LVLW'(i))) ||
                      (compare_wr && (tsel == SELW'(i)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= (base_v & ~clr_v) | set_v;
      err_q  <= bad_cmd;
    end
  end
endmodule

// File: rtl/ipm_irq_gate.sv
module ipm_irq_gate #(
  parameter int NLVL = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] pend_q,
  input  logic [NLVL-1:0] mask,
  input  logic            gie,
  input  logic            exl,
  input  logic            erl,
  output logic            irq_q
);
  logic allowed;
  logic masked_hit;

  always_comb begin
    allowed    = gie && !exl && !erl;
    masked_hit = |(pend_q & mask);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= allowed && masked_hit;
  end
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter int NLVL = 8,
  parameter int LVLW = 4,
  parameter int SELW = $clog2(NLVL),
  parameter int CNTW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [LVLW-1:0] cmd_level,
  input  logic [CNTW-1:0] count_in,
  input  logic [CNTW-1:0] compare_in,
  input  logic            compare_wr,
  input  logic [SELW-1:0] tsel,
  input  logic            gie,
  input  logic            exl,
  input  logic            erl,
  input  logic [NLVL-1:0] mask,
  output logic [NLVL-1:0] pend_out,
  output logic            any_pend,
  output logic            irq,
  output logic            cmd_err
);
  logic            timer_hit;
  logic [NLVL-1:0] pend_q;

  ipm_timer_match #(.CNTW(CNTW)) u_match (
    .count_in  (count_in),
    .compare_in(compare_in),
    .hit       (timer_hit)
  );

  ipm_pend_reg #(.NLVL(NLVL), .LVLW(LVLW), .SELW(SELW)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_level (cmd_level),
    .timer_hit (timer_hit),
    .compare_wr(compare_wr),
    .tsel      (tsel),
    .pend_q    (pend_q),
    .err_q     (cmd_err)
  );

  ipm_irq_gate #(.NLVL(NLVL)) u_gate (
    .clk   (clk),
    .rst   (rst),
    .pend_q(pend_q),
    .mask  (mask),
    .gie   (gie),
    .exl   (exl),
    .erl   (erl),
    .irq_q (irq)
  );

  assign pend_out = pend_q;
  assign any_pend = |pend_q;
endmodule

// File: rtl/irq_pend_unit_chk.sv
module irq_pend_unit_chk #(
  parameter int NLVL = 8,
  parameter int LVLW = 4,
  parameter int SELW = $clog2(NLVL),
  parameter int CNTW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic [LVLW-1:0] cmd_level,
  input logic [CNTW-1:0] count_in,
  input logic [CNTW-1:0] compare_in,
  input logic            compare_wr,
  input logic [SELW-1:0] tsel,
  input logic            gie,
  input logic            exl,
  input logic            erl,
  input logic [NLVL-1:0] mask,
  input logic [NLVL-1:0] pend_out,
  input logic            any_pend,
  input logic            irq,
  input logic            cmd_err
);
  AST_POST_SETS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'b01 && int'(cmd_level) < NLVL)
      |=> pend_out[$past(cmd_level[SELW-1:0])]); // R2

  AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'b11 && (count_in != compare_in || count_in == '0))
      |=> (pend_out == '0)); // R4

  AST_BAD_LEVEL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == 2'b01 || cmd_op == 2'b10) && int'(cmd_level) >= NLVL &&
     !compare_wr && (count_in != compare_in || count_in == '0))
      |=> (cmd_err && $stable(pend_out))); // R5

  AST_TIMER_SETS: assert property (@(posedge clk) disable iff (rst)
    (count_in == compare_in && count_in != '0) |=> pend_out[$past(tsel)]); // R6

  AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!gie || exl || erl) |=> !irq); // R10

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    ((mask & pend_out) == '0) |=> !irq); // R10
endmodule

bind irq_pend_unit irq_pend_unit_chk #(
  .NLVL(NLVL), .LVLW(LVLW), .SELW(SELW), .CNTW(CNTW)
) u_chk (.*);

// File: tb/irq_pend_unit_test.sv
module irq_pend_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [3:0]  cmd_level = 4'd0;
  logic [31:0] count_in = 32'd0;
  logic [31:0] compare_in = 32'd0;
  logic        compare_wr = 1'b0;
  logic [2:0]  tsel = 3'd0;
  logic        gie = 1'b0, exl = 1'b0, erl = 1'b0;
  logic [7:0]  mask = 8'd0;
  logic [7:0]  pend_out;
  logic        any_pend, irq, cmd_err;

  int compared = 0;
  int mismatched = 0;
  int exp_pend = 0;
  bit exp_irq = 0, exp_err = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  irq_pend_unit uut (.*);

  task automatic check(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference: apply one edge with the inputs now present
  task automatic model_edge();
    int nxt, setm, lvl;
    lvl = int'(cmd_level);
    if (rst) begin
      exp_pend = 0; exp_irq = 0; exp_err = 0;
      return;
    end
    exp_irq = gie && !exl && !erl && ((int'(mask) & exp_pend) != 0);
    exp_err = cmd_valid && (cmd_op == 2'b01 || cmd_op == 2'b10) && lvl >= 8;
    nxt = exp_pend;
    setm = 0;
    if (cmd_valid && cmd_op == 2'b11) nxt = 0;
    if (cmd_valid && cmd_op == 2'b10 && lvl < 8) nxt &= ~(1 << lvl);
    if (compare_wr) nxt &= ~(1 << int'(tsel));
    if (cmd_valid && cmd_op == 2'b01 && lvl < 8) setm |= 1 << lvl;
    if (count_in == compare_in && count_in != 0) setm |= 1 << int'(tsel);
    exp_pend = (nxt | setm) & 8'hff;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("pend_out", int'(pend_out), exp_pend);
    check("any_pend R11", int'(any_pend), int'(exp_pend != 0));
    check("irq", int'(irq), int'(exp_irq));
    check("cmd_err", int'(cmd_err), int'(exp_err));
  endtask

  task automatic idle();
    cmd_valid = 0; cmd_op = 2'b00; compare_wr = 0;
  endtask

  task automatic cmd(input logic [1:0] op, input int lvl);
    cmd_valid = 1; cmd_op = op; cmd_level = 4'(lvl);
    cycle();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1"; rst = 1; count_in = 32'd5; compare_in = 32'd9;
    cycle(); cycle();
    rst = 0;
    tag = "R2";
    for (int i = 0; i < 8; i += 2) cmd(2'b01, i);
    cycle();
    tag = "R3"; cmd(2'b10, 4); cmd(2'b10, 1); cmd(2'b10, 0);
    tag = "R4"; cmd(2'b01, 7); cmd(2'b01, 3); cmd(2'b11, 0);
    tag = "R5"; cmd(2'b01, 5);
    for (int l = 8; l < 16; l += 3) begin cmd(2'b01, l); cmd(2'b10, l); end
    cmd(2'b01, 15); cycle();
    tag = "R6"; cmd(2'b11, 0); tsel = 3'd6; count_in = 32'd40; compare_in = 32'd40;
    cycle(); count_in = 32'd41; cycle();
    tag = "R7"; cmd(2'b11, 0); tsel = 3'd2; count_in = 32'd0; compare_in = 32'd0;
    cycle(); cycle();
    tag = "R8"; tsel = 3'd6; count_in = 32'd77; compare_in = 32'd77; cycle();
    compare_in = 32'd100; compare_wr = 1; cycle(); compare_wr = 0;
    count_in = 32'd90; cycle(); cycle(); count_in = 32'd100; cycle();
    tag = "R9"; count_in = 32'd3;
    compare_wr = 1; compare_in = 32'd3; tsel = 3'd1; cycle(); compare_wr = 0;
    compare_in = 32'd8; compare_wr = 1; tsel = 3'd4; cmd(2'b01, 4);
    count_in = 32'd8; cmd(2'b11, 0); tsel = 3'd5; cmd(2'b10, 5);
    count_in = 32'd9; cycle();
    tag = "R10"; cmd(2'b01, 2); mask = 8'h04;
    gie = 0; cycle(); gie = 1; cycle(); cycle();
    exl = 1; cycle(); cycle(); exl = 0; erl = 1; cycle(); cycle(); erl = 0;
    mask = 8'hfb; cycle(); cycle(); mask = 8'hff; cycle(); cmd(2'b11, 0); cycle();
    tag = "R11"; gie = 0; mask = 8'h00; cmd(2'b01, 7); cycle(); cmd(2'b10, 7);
    tag = "R2 R3 R4 R5 R6 R8 R9 R10 random";
    for (int k = 0; k < 3000; k++) begin
      cmd_valid = 1'($urandom);
      cmd_op = 2'($urandom);
      cmd_level = ($urandom % 4 == 0) ? 4'(8 + $urandom % 8) : 4'($urandom % 8);
      count_in = 32'($urandom % 6);
      compare_in = 32'($urandom % 6);
      compare_wr = ($urandom % 5 == 0);
      tsel = 3'($urandom);
      gie = ($urandom % 4 != 0); exl = ($urandom % 6 == 0); erl = ($urandom % 6 == 0);
      mask = 8'($urandom);
      rst = ($urandom % 400 == 0);
      cycle();
    end
    rst = 0; idle(); cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule